// File: doc/BRIEF.md
# Bus-Organized Register File Datapath

This block is a small execution datapath. It holds seven 8-bit general registers, R1 to R7, and has one external data input. Each clock it takes a 14-bit control word. The word chooses an operand for the A bus, an operand for the B bus, an ALU operation and a destination register. Both operand multiplexers can pick any register or the external input. The ALU result drives the external output port combinationally in every cycle. On the next rising edge the result is written into the register that the destination field names, or into no register.

A sequencer or control store upstream supplies one control word per cycle. A value is read out of the datapath by passing a register through the ALU with destination zero. That read leaves every register unchanged.

Top module: `regbus_datapath`

## Requirements
- R1: The control word is split as follows. Bits [13:11] are the A select, bits [10:8] the B select, bits [7:5] the destination select and bits [4:0] the operation code.
- R2: An A or B select of 1 to 7 places register R1 to R7 on that bus. A select of 0 places `ext_in` on that bus.
- R3: Destination code 0 writes no register. `ext_out` still shows the ALU result.
- R4: Destination code d from 1 to 7 loads `ext_out` into Rd on the rising edge. All other registers keep their values.
- R5: `ext_out` equals the ALU result of the current control word and operands in the same cycle, with no register in the path.
- R6: `rst` is synchronous and active high. It clears all seven registers to zero.
- R7: Arithmetic is modulo 256. 00000 gives A, 00001 gives A+1, 00010 gives A+B and 00101 gives A-B.
- R8: Logic operations: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B and 01110 gives NOT A.
- R9: Shifts fill with zero. 10000 gives A shifted right by one and 11000 gives A shifted left by one.
- R10: Any operation code not listed in R7 to R9 passes A through unchanged.
- R11: When a register is both a source and the destination, the ALU uses its old value and the result replaces it at the edge. For example, R5 <= R5 XOR R5 leaves R5 at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | A select, B select, destination select and operation code |
| ext_in | input | 8 | External operand, selected by source code 0 |
| ext_out | output | 8 | ALU result |

## Verification
A wrong register value reaches `ext_out` only when a later control word routes that register onto a bus. The bench therefore follows every write, and every destination-zero operation, with reads of the affected registers. Any error then appears within one or two cycles. The ALU path has no register, so a wrong operation decode or a wrong bus select shows on `ext_out` in the same cycle as the control word that exercises it.

// File: rtl/regbus_datapath.sv
`timescale 1ns/1ps
module regbus_datapath #(
  parameter int W    = 8,
  parameter int SELW = 3,
  parameter int OPW  = 5,
  localparam int NREG = (1 << SELW) - 1,
  localparam int CW   = 3 * SELW + OPW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ctrl_word,
  input  logic [W-1:0]  ext_in,
  output logic [W-1:0]  ext_out
);
  localparam logic [OPW-1:0] OP_PASS = OPW'(5'b00000);
  localparam logic [OPW-1:0] OP_INC  = OPW'(5'b00001);
  localparam logic [OPW-1:0] OP_ADD  = OPW'(5'b00010);
  localparam logic [OPW-1:0] OP_SUB  = OPW'(5'b00101);
  localparam logic [OPW-1:0] OP_AND  = OPW'(5'b01000);
  localparam logic [OPW-1:0] OP_OR   = OPW'(5'b01010);
  localparam logic [OPW-1:0] OP_XOR  = OPW'(5'b01100);
  localparam logic [OPW-1:0] OP_NOT  = OPW'(5'b01110);
  localparam logic [OPW-1:0] OP_SHR  = OPW'(5'b10000);
  localparam logic [OPW-1:0] OP_SHL  = OPW'(5'b11000);

  logic [NREG:1][W-1:0] rf;
  logic [SELW-1:0] asel, bsel, dsel;
  logic [OPW-1:0]  opc;
  logic [W-1:0]    a_bus, b_bus;

  assign {asel, bsel, dsel, opc} = ctrl_word;
  assign a_bus = (asel == '0) ? ext_in : rf[asel];
  assign b_bus = (bsel == '0) ? ext_in : rf[bsel];

  always_comb begin
    case (opc)
      OP_PASS: ext_out = a_bus;
      OP_INC:  ext_out = a_bus + W'(1);
      OP_ADD:  ext_out = a_bus + b_bus;
      OP_SUB:  ext_out = a_bus - b_bus;
      OP_AND:  ext_out = a_bus & b_bus;
      OP_OR:   ext_out = a_bus | b_bus;
      OP_XOR:  ext_out = a_bus ^ b_bus;
      OP_NOT:  ext_out = ~a_bus;
      OP_SHR:  ext_out = a_bus >> 1;
      OP_SHL:  ext_out = a_bus << 1;
      default: ext_out = a_bus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rf <= '0;
    else if (dsel != '0)
      rf[dsel] <= ext_out;
  end
endmodule

// File: rtl/regbus_datapath_chk.sv
`timescale 1ns/1ps
module regbus_datapath_chk #(
  parameter int W    = 8,
  parameter int SELW = 3,
  parameter int OPW  = 5,
  localparam int NREG = (1 << SELW) - 1,
  localparam int CW   = 3 * SELW + OPW
) (
  input logic                 clk,
  input logic                 rst,
  input logic [CW-1:0]        ctrl_word,
  input logic [W-1:0]         ext_in,
  input logic [W-1:0]         ext_out,
  input logic [NREG:1][W-1:0] rf
);
  logic [SELW-1:0] c_a, c_b, c_d;
  logic [OPW-1:0]  c_op;
  logic [SELW-1:0] last_d;
  logic [W-1:0]    last_out;
  assign {c_a, c_b, c_d, c_op} = ctrl_word;

  always_ff @(posedge clk) begin
    last_d   <= c_d;
    last_out <= ext_out;
  end

  a_r6_reset_clears: assert property (@(posedge clk) rst |=> (rf == '0));

  a_r4_dest_loads: assert property (@(posedge clk) disable iff (rst)
    (c_d != '0) |=> (rf[last_d] == last_out));

  for (genvar i = 1; i <= NREG; i++) begin : g_hold
    a_r3_r4_others_hold: assert property (@(posedge clk) disable iff (rst)
      (c_d != SELW'(i)) |=> $stable(rf[i]));
  end

  a_r2_ext_select: assert property (@(posedge clk) disable iff (rst)
    (c_a == '0 && c_op == '0) |-> (ext_out == ext_in));

  a_r11_self_xor_zero: assert property (@(posedge clk) disable iff (rst)
    (c_a == c_b && c_op == OPW'(5'b01100)) |-> (ext_out == '0));
endmodule

bind regbus_datapath regbus_datapath_chk #(.W(W), .SELW(SELW), .OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
  .ext_out(ext_out), .rf(rf)
);

// File: tb/regbus_datapath_test.sv
`timescale 1ns/1ps
module regbus_datapath_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_in = '0;
  logic [7:0]  ext_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] model [1:7];

  always #2 clk = ~clk;

  regbus_datapath uut (.clk(clk), .rst(rst), .ctrl_word(ctrl_word),
                       .ext_in(ext_in), .ext_out(ext_out));

  function automatic logic [7:0] ref_alu(input logic [4:0] op,
                                         input logic [7:0] a, input logic [7:0] b);
    case (op)
      5'b00000: return a;
      5'b00001: return 8'(a + 8'd1);
      5'b00010: return 8'(a + b);
      5'b00101: return 8'(a - b);
      5'b01000: return a & b;
      5'b01010: return a | b;
      5'b01100: return a ^ b;
      5'b01110: return ~a;
      5'b10000: return {1'b0, a[7:1]};
      5'b11000: return {a[6:0], 1'b0};
      default:  return a;
    endcase
  endfunction

  task automatic apply(input logic [2:0] a, input logic [2:0] b, input logic [2:0] d,
                       input logic [4:0] op, input logic [7:0] ext, input string tag);
    logic [7:0] av, bv, res;
    @(negedge clk);
    ctrl_word = {a, b, d, op};
    ext_in = ext;
    av = (a == 3'd0) ? ext : model[a];
    bv = (b == 3'd0) ? ext : model[b];
    res = ref_alu(op, av, bv);
    exp_q.push_back(res);
    tag_q.push_back(tag);
    if (d != 3'd0) model[d] = res;
  endtask

  task automatic read_reg(input logic [2:0] r, input string tag);
    apply(r, 3'd0, 3'd0, 5'b00000, 8'h00, tag);
  endtask

  initial begin : monitor
    logic [7:0] e;
    string t;
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (ext_out !== e) begin
          errors++;
          $display("FAIL %s: ext_out=%h expected=%h", t, ext_out, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 1; i <= 7; i++) model[i] = 8'h00;
    // R6: a write is requested while reset is held
    @(negedge clk);
    rst = 1'b1;
    ctrl_word = {3'd0, 3'd0, 3'd1, 5'b00000};
    ext_in = 8'hAA;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ctrl_word = '0;
    for (int i = 1; i <= 7; i++) read_reg(3'(i), "R6 reset value");

    // R4, R2: load each register from the external input, then read back
    for (int i = 1; i <= 7; i++) apply(3'd0, 3'd0, 3'(i), 5'b00000, 8'(8'h11 * i), "R4 load");
    for (int i = 1; i <= 7; i++) read_reg(3'(i), "R2/R4 read back");

    // R1: a hand-built word, R1 <= R2 + R3
    @(negedge clk);
    ctrl_word = 14'b010_011_001_00010;
    ext_in = 8'h00;
    exp_q.push_back(8'h55);
    tag_q.push_back("R1 field layout add");
    model[1] = 8'h55;
    read_reg(3'd1, "R1 R4 destination result");

    // R7 arithmetic
    apply(3'd7, 3'd2, 3'd0, 5'b00101, 8'h00, "R7 subtract");
    apply(3'd2, 3'd7, 3'd0, 5'b00101, 8'h00, "R7 subtract wrap");
    apply(3'd0, 3'd0, 3'd4, 5'b00001, 8'hFF, "R7 increment wrap");
    read_reg(3'd4, "R7 increment stored");
    apply(3'd0, 3'd6, 3'd0, 5'b00010, 8'hC0, "R7 add carry out dropped");

    // R8 logic
    apply(3'd0, 3'd3, 3'd0, 5'b01000, 8'h0F, "R8 AND");
    apply(3'd0, 3'd3, 3'd0, 5'b01010, 8'hF0, "R8 OR");
    apply(3'd0, 3'd5, 3'd0, 5'b01100, 8'hFF, "R8 XOR");
    apply(3'd6, 3'd0, 3'd0, 5'b01110, 8'h00, "R8 complement");

    // R9 shifts
    apply(3'd0, 3'd0, 3'd2, 5'b10000, 8'h81, "R9 shift right");
    read_reg(3'd2, "R9 shift right stored");
    apply(3'd0, 3'd0, 3'd0, 5'b11000, 8'h81, "R9 shift left");

    // R10 unlisted codes
    apply(3'd3, 3'd5, 3'd0, 5'b00011, 8'h00, "R10 unlisted code");
    apply(3'd0, 3'd5, 3'd0, 5'b11111, 8'h3C, "R10 unlisted code ext");

    // R3 and R5: destination zero shows the result and keeps every register
    apply(3'd1, 3'd1, 3'd0, 5'b00010, 8'h00, "R3 R5 dest zero output");
    for (int i = 1; i <= 7; i++) read_reg(3'(i), "R3 registers unchanged");

    // R11: the same register as source and destination
    apply(3'd5, 3'd5, 3'd5, 5'b01100, 8'h00, "R11 self xor");
    read_reg(3'd5, "R11 self xor clears");
    apply(3'd6, 3'd6, 3'd6, 5'b00010, 8'h00, "R11 self add old value");
    read_reg(3'd6, "R11 self add stored");
    apply(3'd6, 3'd0, 3'd6, 5'b00001, 8'h00, "R11 back-to-back update");
    read_reg(3'd6, "R11 back-to-back stored");

    // R6: a second reset clears registers loaded earlier
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 1; i <= 7; i++) model[i] = 8'h00;
    read_reg(3'd1, "R6 second reset");
    read_reg(3'd7, "R6 second reset");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule